// File: doc/BRIEF.md
# Two-Beat Double-Width SRAM Datapath

This block is the datapath of a synchronous single-port SRAM whose internal array word is twice as wide as its external data bus. A single beat clock runs the whole block, and every operation moves exactly two data beats. For a write, the block collects both incoming beats with their own active-low byte masks. It then commits one double-width word to the array in a single update. For a read, it fetches one double-width word and returns the two halves on consecutive beats.

An operation starts when the load strobe is low. The read/write select picks the direction. Writes are late writes: the data follows on the two beats after the address beat. Read data comes back after a fixed delay and carries a valid flag. With the critical-word-first option enabled, the lowest address bit chooses which half travels first. With the option disabled, that bit is not an input and the halves always travel lower half first. A read issued straight after a write sees the write's data, merged lane by lane, even though the write has not yet reached the array.

Top module: `sram2_b2`

## Requirements
- R1: While reset is held and on the first beat after it is released, `dout_vld` is 0, `dout` is 0 and `err_ld` is 0.
- R2: When `ld_n` is 0 on a beat where a load is allowed, an operation starts: a read if `rw` is 1, a write if `rw` is 0.
- R3: Read data appears on the 2nd and 3rd beats after the address beat, with `dout_vld` high on both. On every beat where `dout_vld` is low, `dout` is all zeros.
- R4: With `CWF`=1, the array index is `addr[ADDR_W-1:1]` and `addr[0]` selects the leading half. The leading half is the one carried on the first beat of both reads and writes. When `addr[0]` is 0 the leading half is array bits [DW-1:0], and when it is 1 it is bits [2*DW-1:DW]. The other half goes on the second beat.
- R5: With `CWF`=0, `addr` is `IDX_W` bits and is used entirely as the index. The first beat always maps to array bits [DW-1:0] and the second beat to bits [2*DW-1:DW].
- R6: Write data is taken on the 1st and 2nd beats after the address beat. Both beats are written into the array word together.
- R7: `bw_n[b]` low on a write beat stores data bits [8b+7:8b] of that beat into lane b of its half. A high bit leaves that lane of that half unchanged. Each beat uses its own mask.
- R8: A write with every `bw_n` bit high on both beats leaves the array word unchanged.
- R9: A read of an index, loaded in the beat right after a write's second data beat is due, returns the write's new lanes merged with the old contents.
- R10: A load asserted on the second beat of an accepted operation is ignored: it starts nothing, moves no data, and causes `err_ld` to be high for exactly the next beat.
- R11: Loads may be accepted every second beat, back to back, without losing or reordering data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_n | input | 1 | Active-low load strobe |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Beat address (index plus, with CWF=1, the order bit in bit 0) |
| bw_n | input | LANES | Active-low byte lane enables, per data beat |
| din | input | LANES*LANE_W | Write data beat |
| dout | output | LANES*LANE_W | Read data beat, zero when not valid |
| dout_vld | output | 1 | Marks a valid read beat |
| err_ld | output | 1 | One-beat pulse after an ignored load |

## Verification
A stale captured first beat or a wrong half pointer corrupts one half of a later read, and that shows on `dout` at most three beats after the read is loaded. A broken beat phase tracker appears within one beat, either as a missing or extra `err_ld` pulse or as a read burst that is missing, duplicated or shifted in time. The scoreboard catches any of these by its cycle stamp. A failed same-index bypass shows only on a read placed in the slot right after a write, so the bench makes that pairing under every mask combination.

// File: rtl/sram2_pkg.sv
package sram2_pkg;
  typedef enum logic {OP_WRITE = 1'b0, OP_READ = 1'b1} op_e;

  // half that travels on the first beat
  function automatic logic lead_half(input bit cwf, input logic a0);
    return cwf ? a0 : 1'b0;
  endfunction
endpackage

// File: rtl/sram2_wr_gather.sv
module sram2_wr_gather #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cap_en,
  input  logic                        lead,
  input  logic [LANES*LANE_W-1:0]     din,
  input  logic [LANES-1:0]            bw_n,
  output logic [2*LANES*LANE_W-1:0]   cm_data,
  output logic [2*LANES-1:0]          cm_wen
);
  localparam int DW = LANES * LANE_W;

  logic [DW-1:0]    b1_d;
  logic [LANES-1:0] b1_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b1_d  <= '0;
      b1_en <= '0;
    end else if (cap_en) begin
      b1_d  <= din;
      b1_en <= ~bw_n;
    end
  end

  // first beat goes to the leading half, live beat to the other
  always_comb begin
    if (lead) begin
      cm_data = {b1_d, din};
      cm_wen  = {b1_en, ~bw_n};
    end else begin
      cm_data = {din, b1_d};
      cm_wen  = {~bw_n, b1_en};
    end
  end

  // R7: first-beat mask held per beat
  assert_first_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> b1_en == ~$past(bw_n));
endmodule

// File: rtl/sram2_array.sv
module sram2_array #(
  parameter int IDX_W  = 4,
  parameter int LANE_W = 8,
  parameter int NL     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [IDX_W-1:0]     widx,
  input  logic [NL*LANE_W-1:0] wdata,
  input  logic [NL-1:0]        wen,
  input  logic [IDX_W-1:0]     ridx,
  output logic [NL*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int WW    = NL * LANE_W;

  logic [WW-1:0] mem [DEPTH];

  for (genvar l = 0; l < NL; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (we && wen[l]) mem[widx][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
    end
  end

  assign rdata = mem[ridx];

  wire abort_evt = we && (wen == '0);

  // R8: a fully masked commit keeps the word
  assert_abort_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> mem[$past(widx)] == $past(mem[widx]));
  // R7: an enabled lane takes the new byte
  assert_lane_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wen[0]) |=> mem[$past(widx)][LANE_W-1:0] == $past(wdata[LANE_W-1:0]));
endmodule

// File: rtl/sram2_rd_mux.sv
module sram2_rd_mux #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_en,
  input  logic [2*DW-1:0] fetch_word,
  input  logic            lead,
  output logic [DW-1:0]   dout,
  output logic            dout_vld
);
  logic [2*DW-1:0] hold_w;
  logic            hold_h, st_a, st_b;
  logic [DW-1:0]   q;
  logic            v;

  function automatic logic [DW-1:0] pick(input logic [2*DW-1:0] w, input logic h);
    return h ? w[2*DW-1:DW] : w[DW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_w <= '0;
      hold_h <= 1'b0;
      st_a   <= 1'b0;
      st_b   <= 1'b0;
      q      <= '0;
      v      <= 1'b0;
    end else begin
      st_a <= fetch_en;
      st_b <= st_a;
      if (fetch_en) begin
        hold_w <= fetch_word;
        hold_h <= lead;
      end
      if (st_a) begin
        q <= pick(hold_w, hold_h);
        v <= 1'b1;
      end else if (st_b) begin
        q <= pick(hold_w, ~hold_h);
        v <= 1'b1;
      end else begin
        q <= '0;
        v <= 1'b0;
      end
    end
  end

  assign dout     = q;
  assign dout_vld = v;

  // R3: beats come in pairs, output quiet otherwise
  assert_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_vld) |=> dout_vld);
  assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_vld |-> dout == '0);
  assert_one_stage_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_a, st_b}));
endmodule

// File: rtl/sram2_b2.sv
module sram2_b2
  import sram2_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  parameter int IDX_W  = 4,
  parameter bit CWF    = 1'b1,
  parameter int ADDR_W = IDX_W + (CWF ? 1 : 0)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_n,
  input  logic                    rw,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        bw_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_vld,
  output logic                    err_ld
);
  localparam int DW = LANES * LANE_W;
  localparam int WW = 2 * DW;
  localparam int NL = 2 * LANES;

  logic [IDX_W-1:0] cur_idx;
  logic             cur_lead;

  if (CWF) begin : g_cwf
    assign cur_idx  = addr[ADDR_W-1:1];
    assign cur_lead = lead_half(1'b1, addr[0]);
  end else begin : g_fixed
    assign cur_idx  = addr[IDX_W-1:0];
    assign cur_lead = lead_half(1'b0, 1'b0);
  end

  logic second_q, err_q, wr1_q, wr2_q, wr_lead_q;
  logic [IDX_W-1:0] wr_idx_q;

  wire ld_acc  = !ld_n && !second_q;
  wire ld_drop = !ld_n && second_q;
  wire rd_acc  = ld_acc && (rw == OP_READ);
  wire wr_acc  = ld_acc && (rw == OP_WRITE);
  wire commit_evt = wr2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      second_q  <= 1'b0;
      err_q     <= 1'b0;
      wr1_q     <= 1'b0;
      wr2_q     <= 1'b0;
      wr_lead_q <= 1'b0;
      wr_idx_q  <= '0;
    end else begin
      second_q <= ld_acc;
      err_q    <= ld_drop;
      wr1_q    <= wr_acc;
      wr2_q    <= wr1_q;
      if (wr_acc) begin
        wr_idx_q  <= cur_idx;
        wr_lead_q <= cur_lead;
      end
    end
  end

  logic [WW-1:0] cm_data, rdata, fetch_word;
  logic [NL-1:0] cm_wen;

  sram2_wr_gather #(.LANES(LANES), .LANE_W(LANE_W)) u_gather (
    .clk(clk), .rst_n(rst_n), .cap_en(wr1_q), .lead(wr_lead_q),
    .din(din), .bw_n(bw_n), .cm_data(cm_data), .cm_wen(cm_wen));

  sram2_array #(.IDX_W(IDX_W), .LANE_W(LANE_W), .NL(NL)) u_array (
    .clk(clk), .rst_n(rst_n), .we(commit_evt), .widx(wr_idx_q),
    .wdata(cm_data), .wen(cm_wen), .ridx(cur_idx), .rdata(rdata));

  function automatic logic [WW-1:0] merge_lanes(input logic [WW-1:0] old_w,
                                                input logic [WW-1:0] new_w,
                                                input logic [NL-1:0] en);
    logic [WW-1:0] r;
    r = old_w;
    for (int l = 0; l < NL; l++)
      if (en[l]) r[l*LANE_W +: LANE_W] = new_w[l*LANE_W +: LANE_W];
    return r;
  endfunction

  // same-edge commit to the fetched index: forward its lanes
  wire bypass_hit = commit_evt && (wr_idx_q == cur_idx);
  assign fetch_word = bypass_hit ? merge_lanes(rdata, cm_data, cm_wen) : rdata;

  sram2_rd_mux #(.DW(DW)) u_rdmux (
    .clk(clk), .rst_n(rst_n), .fetch_en(rd_acc), .fetch_word(fetch_word),
    .lead(cur_lead), .dout(dout), .dout_vld(dout_vld));

  assign err_ld = err_q;

  assert_spacing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_acc |=> !ld_acc);
  assert_drop_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_drop |=> err_ld);
  assert_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> ##1 dout_vld);
  assert_write_beats_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> ##1 commit_evt);
  // R2: a load with the read select starts a read, never a write
  assert_read_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> !wr1_q);
endmodule

// File: tb/tb_sram2_b2.sv
module tb_sram2_b2;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_n = 1'b1, rw = 1'b1;
  logic [4:0] addr = '0;
  logic [1:0] bw_n = 2'b11;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout_c, dout_f;
  logic vld_c, vld_f, err_c, err_f;

  always #10 clk = ~clk;

  sram2_b2 #(.CWF(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
    .bw_n(bw_n), .din(din), .dout(dout_c), .dout_vld(vld_c), .err_ld(err_c));

  sram2_b2 #(.CWF(1'b0)) dut_fix (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr[4:1]),
    .bw_n(bw_n), .din(din), .dout(dout_f), .dout_vld(vld_f), .err_ld(err_f));

  typedef struct packed { int cyc; logic [DW-1:0] d; } exp_t;
  exp_t qc[$];
  exp_t qf[$];
  logic [2*DW-1:0] ref_c [16];
  logic [2*DW-1:0] ref_f [16];

  int checks = 0, errors = 0, cyc = 0, err_due = -1;
  bit started = 0, done = 0;
  bit p2_v = 0;
  logic [DW-1:0] p2_d;
  logic [1:0] p2_m;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [2*DW-1:0] apply(input logic [2*DW-1:0] w, input bit lead,
      input logic [DW-1:0] d1, input logic [1:0] m1, input logic [DW-1:0] d2, input logic [1:0] m2);
    logic [2*DW-1:0] r;
    r = w;
    for (int l = 0; l < 2; l++) begin
      if (!m1[l]) r[int'(lead)*DW + l*8 +: 8] = d1[l*8 +: 8];
      if (!m2[l]) r[int'(!lead)*DW + l*8 +: 8] = d2[l*8 +: 8];
    end
    return r;
  endfunction

  // scoreboard monitor: R3 timing and quiet bus, R4/R5 order, R10 flag
  always @(negedge clk) begin : monitor
    exp_t e;
    if (started) begin
      if (vld_c) begin
        if (qc.size() == 0) chk(0, "R3 unexpected beat (cwf)", dout_c, 0);
        else begin
          e = qc.pop_front();
          chk(e.cyc == cyc && e.d == dout_c, "R3/R4 beat (cwf)", {cyc[15:0], dout_c}, {e.cyc[15:0], e.d});
        end
      end else chk(dout_c == '0, "R3 idle bus (cwf)", dout_c, 0);
      if (vld_f) begin
        if (qf.size() == 0) chk(0, "R3 unexpected beat (fixed)", dout_f, 0);
        else begin
          e = qf.pop_front();
          chk(e.cyc == cyc && e.d == dout_f, "R5 beat (fixed)", {cyc[15:0], dout_f}, {e.cyc[15:0], e.d});
        end
      end else chk(dout_f == '0, "R3 idle bus (fixed)", dout_f, 0);
      chk(err_c == (cyc == err_due), "R10 err flag (cwf)", err_c, cyc == err_due);
      chk(err_f == (cyc == err_due), "R10 err flag (fixed)", err_f, cyc == err_due);
    end
  end

  task automatic drive_beat2();
    if (p2_v) begin din = p2_d; bw_n = p2_m; end
    else begin din = 16'hDEAD; bw_n = 2'b11; end
    p2_v = 0;
  endtask

  // one two-beat slot; bad=1 adds an illegal load on the second beat (R10)
  task automatic op(input bit rd, input int idx, input bit a0,
                    input logic [DW-1:0] d1, input logic [1:0] m1,
                    input logic [DW-1:0] d2, input logic [1:0] m2, input bit bad);
    logic [2*DW-1:0] wc, wf;
    @(negedge clk);
    ld_n = 0; rw = rd; addr = {idx[3:0], a0};
    drive_beat2();
    if (rd) begin
      wc = ref_c[idx]; wf = ref_f[idx];
      qc.push_back('{cyc + 2, a0 ? wc[2*DW-1:DW] : wc[DW-1:0]});
      qc.push_back('{cyc + 3, a0 ? wc[DW-1:0] : wc[2*DW-1:DW]});
      qf.push_back('{cyc + 2, wf[DW-1:0]});
      qf.push_back('{cyc + 3, wf[2*DW-1:DW]});
    end else begin
      ref_c[idx] = apply(ref_c[idx], a0, d1, m1, d2, m2);
      ref_f[idx] = apply(ref_f[idx], 1'b0, d1, m1, d2, m2);
    end
    @(negedge clk);
    if (bad) begin
      ld_n = 0; rw = 0; addr = ~addr; err_due = cyc + 1;
    end else ld_n = 1;
    if (rd) begin din = 16'hBEEF; bw_n = 2'b00; end
    else begin
      din = d1; bw_n = m1;
      p2_v = 1; p2_d = d2; p2_m = m2;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    ld_n = 1; rw = 1;
    drive_beat2();
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!vld_c && dout_c == 0 && !err_c, "R1 reset state (cwf)", {vld_c, err_c, dout_c}, 0);
    chk(!vld_f && dout_f == 0 && !err_f, "R1 reset state (fixed)", {vld_f, err_f, dout_f}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!vld_c && dout_c == 0 && !err_c, "R1 after release", {vld_c, err_c, dout_c}, 0);
    started = 1;

    // R2/R6/R11: fill every index back to back with full masks
    for (int i = 0; i < 16; i++) begin
      ref_c[i] = '0; ref_f[i] = '0;
      op(0, i, i[0], 16'hA100 + 16'(i), 2'b00, 16'hB200 + 16'(i), 2'b00, 0);
    end
    // R4/R5/R11: stream reads with both order bits
    for (int i = 0; i < 16; i++) op(1, i, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) op(1, i, 1, 0, 0, 0, 0, 0);
    idle(); idle();

    // R7/R9: every mask pair, read straight after (bypass) and again later
    for (int m = 0; m < 16; m++) begin
      op(0, 5, m[0], 16'h1100 * 16'(m + 1), 2'(m), 16'h0F0F ^ 16'(m * 257), 2'(m >> 2), 0);
      op(1, 5, m[1], 0, 0, 0, 0, 0);
      idle();
      op(1, 5, ~m[1], 0, 0, 0, 0, 0);
    end

    // R8: abort leaves the word alone, checked by bypass and by later read
    op(0, 9, 1, 16'hFFFF, 2'b11, 16'hEEEE, 2'b11, 0);
    op(1, 9, 0, 0, 0, 0, 0, 0);
    idle(); idle();
    op(1, 9, 1, 0, 0, 0, 0, 0);

    // R10: illegal loads on a write's and a read's second beat
    op(0, 3, 0, 16'h3333, 2'b00, 16'h4444, 2'b00, 1);
    op(1, 3, 1, 0, 0, 0, 0, 1);
    idle(); idle();
    op(1, 12, 0, 0, 0, 0, 0, 0);
    op(1, 3, 0, 0, 0, 0, 0, 0);
    repeat (6) idle();

    chk(qc.size() == 0, "R3 all reads returned (cwf)", qc.size(), 0);
    chk(qf.size() == 0, "R3 all reads returned (fixed)", qf.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule